// File: doc/BRIEF.md
# Four-Tap Bit-Serial Distributed-Arithmetic FIR Filter

This block is a four-tap finite impulse response filter that uses no multipliers. Each accepted sample enters a four-deep history. The filter then walks through the bit positions of the stored samples, least significant first. In each step it takes the same bit from all four taps and uses those four bits as an address into a sixteen-entry table. Each table entry holds a precomputed sum of the fixed coefficients. A scaling accumulator weights each table word by the power of two of its bit position. The word read during the sign-bit step is subtracted, because the samples are in two's complement.

The host offers a parallel sample with a valid strobe, and the sample is taken when the ready flag is high. Ready falls for the whole serial pass. The full-precision result appears on a parallel output together with a one-cycle done pulse. With a sample width of B bits, the filter accepts one sample every B+1 clocks. The coefficients are fixed when the block is elaborated.

Top module: `da_fir4_serial`

## Requirements
- R1: While reset is applied and after it is released, `in_ready` is 1, `out_done` is 0 and `out_result` is 0. The sample history holds four zero samples.
- R2: After each accepted sample, `out_result` equals C0·x[n] + C1·x[n-1] + C2·x[n-2] + C3·x[n-3] in full precision. Here x[n] is the newest accepted sample, and samples and result are two's-complement signed.
- R3: `out_done` is high for exactly one cycle, in the cycle after the B-th rising edge that follows the accepting edge. `out_result` is updated at that same edge.
- R4: A sample is accepted at a rising edge where both `in_valid` and `in_ready` are 1. `in_ready` is 0 from the next cycle until the done cycle, and is 1 again in the done cycle, so a new sample can be accepted every B+1 clocks.
- R5: `in_valid` and `in_sample` have no effect while `in_ready` is 0. Such a sample never enters the history or any later result.
- R6: The history shifts only when a sample is accepted. Idle cycles with `in_valid` low leave later results unchanged.
- R7: `out_result` holds its value in every cycle in which `out_done` is 0.
- R8: Table address bit k is bit b of tap k, where tap 0 is the newest sample. The table returns the sum of the coefficients whose address bit is set. An impulse of 1 followed by zeros therefore gives the results C0, C1, C2, C3 in turn.
- R9: The sign-bit weight is negative. The most negative sample, -2^(B-1), and the most positive, 2^(B-1)-1, give exact results with no overflow in the B+COEF_W+2 bit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_sample | input | DATA_W | Signed sample |
| in_ready | output | 1 | High when a sample can be taken |
| out_result | output | DATA_W+COEF_W+2 | Signed filter output |
| out_done | output | 1 | One-cycle pulse when `out_result` is updated |

## Verification
The accepting edge is counted as edge zero. `in_ready` must read 0 at every falling edge after edges 0 through B-1. At the falling edge after edge B, `out_done` must be 1, `in_ready` must be 1 and `out_result` must match the expected value. At the falling edge after the next accepting edge, `out_done` must read 0 again. The bench drives and samples only on falling edges, so every comparison falls in a known cycle of this B+1 clock schedule. During idle gaps the bench checks that the result holds. Samples offered while the filter is busy are left out of the bench's own history model, so accepting one would show up as a mismatch in a later result.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    localparam int TAPS     = 4;
    localparam int TBL_SIZE = 1 << TAPS;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } da_state_e;

endpackage

// File: rtl/da_coef_rom.sv
module da_coef_rom #(
    parameter int COEF_W = 8,
    parameter int COEF0  = 37,
    parameter int COEF1  = -90,
    parameter int COEF2  = 115,
    parameter int COEF3  = -17,
    localparam int TW    = COEF_W + 2
) (
    input  logic [da_fir_pkg::TAPS-1:0] addr,
    output logic signed [TW-1:0]        word
);
    import da_fir_pkg::*;

    logic signed [TW-1:0] tbl [TBL_SIZE];

    // each entry is the sum of coefficients whose address bit is set
    for (genvar a = 0; a < TBL_SIZE; a++) begin : g_entry
        localparam int ENTRY = (((a >> 0) & 1) != 0 ? COEF0 : 0)
                             + (((a >> 1) & 1) != 0 ? COEF1 : 0)
                             + (((a >> 2) & 1) != 0 ? COEF2 : 0)
                             + (((a >> 3) & 1) != 0 ? COEF3 : 0);
        assign tbl[a] = TW'(ENTRY);
    end

    always_comb begin
        word = tbl[addr];
    end

endmodule

// File: rtl/da_tap_line.sv
module da_tap_line #(
    parameter int DATA_W = 8,
    localparam int IW    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic [DATA_W-1:0]           din,
    input  logic [IW-1:0]               bit_sel,
    output logic [da_fir_pkg::TAPS-1:0] slice
);
    import da_fir_pkg::*;

    logic [TAPS-1:0][DATA_W-1:0] taps_d, taps_q;

    always_comb begin
        taps_d = taps_q;
        if (shift_en) begin
            taps_d = {taps_q[TAPS-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps_q <= '0;
        end else begin
            taps_q <= taps_d;
        end
    end

    // one bit of the same weight from every tap forms the table address
    for (genvar k = 0; k < TAPS; k++) begin : g_slice
        assign slice[k] = taps_q[k][bit_sel];
    end

endmodule

// File: rtl/da_scale_acc.sv
module da_scale_acc #(
    parameter int DATA_W = 8,
    parameter int TW     = 10,
    parameter int OUT_W  = 18,
    localparam int AW    = OUT_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step_en,
    input  logic                    sign_step,
    input  logic signed [TW-1:0]    tbl_word,
    output logic signed [OUT_W-1:0] total
);
    logic signed [AW-1:0] acc_d, acc_q;
    logic signed [AW-1:0] ext_word;
    logic signed [AW-1:0] addend;
    logic signed [AW-1:0] step_sum;

    always_comb begin
        ext_word = AW'(tbl_word);
        addend   = ext_word <<< (DATA_W - 1);
        step_sum = sign_step ? (acc_q - addend) : (acc_q + addend);
        acc_d    = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (step_en) begin
            acc_d = sign_step ? step_sum : (step_sum >>> 1);
        end
        total = step_sum[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/da_fir4_serial.sv
module da_fir4_serial #(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int COEF0  = 37,
    parameter int COEF1  = -90,
    parameter int COEF2  = 115,
    parameter int COEF3  = -17,
    localparam int OUT_W = DATA_W + COEF_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic              in_ready,
    output logic [OUT_W-1:0]  out_result,
    output logic              out_done
);
    import da_fir_pkg::*;

    localparam int TW = COEF_W + 2;
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

    typedef struct packed {
        da_state_e        state;
        logic [IW-1:0]    idx;
        logic [OUT_W-1:0] result;
        logic             done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic                    accept;
    logic                    running;
    logic                    sign_step;
    logic [TAPS-1:0]         slice;
    logic signed [TW-1:0]    tbl_word;
    logic signed [OUT_W-1:0] total;

    always_comb begin
        accept    = in_valid && (ctrl_q.state == ST_IDLE);
        running   = (ctrl_q.state == ST_RUN);
        sign_step = running && (ctrl_q.idx == LAST_IDX);

        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        if (accept) begin
            ctrl_d.state = ST_RUN;
            ctrl_d.idx   = '0;
        end else if (running) begin
            if (sign_step) begin
                ctrl_d.state  = ST_IDLE;
                ctrl_d.idx    = '0;
                ctrl_d.result = total;
                ctrl_d.done   = 1'b1;
            end else begin
                ctrl_d.idx = ctrl_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, idx: '0, result: '0, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    da_tap_line #(
        .DATA_W (DATA_W)
    ) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      (in_sample),
        .bit_sel  (ctrl_q.idx),
        .slice    (slice)
    );

    da_coef_rom #(
        .COEF_W (COEF_W),
        .COEF0  (COEF0),
        .COEF1  (COEF1),
        .COEF2  (COEF2),
        .COEF3  (COEF3)
    ) u_rom (
        .addr (slice),
        .word (tbl_word)
    );

    da_scale_acc #(
        .DATA_W (DATA_W),
        .TW     (TW),
        .OUT_W  (OUT_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .step_en   (running),
        .sign_step (sign_step),
        .tbl_word  (tbl_word),
        .total     (total)
    );

    assign in_ready   = (ctrl_q.state == ST_IDLE);
    assign out_result = ctrl_q.result;
    assign out_done   = ctrl_q.done;

endmodule

// File: rtl/da_fir4_serial_chk.sv
module da_fir4_serial_chk #(
    parameter int DATA_W = 8,
    parameter int OUT_W  = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [OUT_W-1:0] out_result,
    input logic             out_done
);
    localparam int CW = $clog2(DATA_W + 2);

    logic [CW-1:0] since_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_acc <= '0;
        end else if (in_valid && in_ready) begin
            since_acc <= CW'(1);
        end else if (since_acc != '0 && since_acc < CW'(DATA_W)) begin
            since_acc <= since_acc + 1'b1;
        end else begin
            since_acc <= '0;
        end
    end

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);

    // R3
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_acc == CW'(DATA_W)) |=> out_done);

    // R3
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> ($past(since_acc) == CW'(DATA_W)));

    // R4
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R4
    ready_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> in_ready);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_done |-> $stable(out_result));

endmodule

bind da_fir4_serial da_fir4_serial_chk #(
    .DATA_W (DATA_W),
    .OUT_W  (OUT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_result (out_result),
    .out_done   (out_done)
);

// File: tb/da_fir4_serial_bench.sv
module da_fir4_serial_bench;

    localparam int CLK_PERIOD = 10;
    localparam int B   = 8;
    localparam int CW  = 8;
    localparam int OW  = B + CW + 2;
    localparam int K0  = 37;
    localparam int K1  = -90;
    localparam int K2  = 115;
    localparam int K3  = -17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [B-1:0]  in_sample = '0;
    logic          in_ready;
    logic [OW-1:0] out_result;
    logic          out_done;

    int checks   = 0;
    int failures = 0;
    int hist [4] = '{0, 0, 0, 0};
    int last_exp = 0;
    bit finished = 1'b0;

    da_fir4_serial #(
        .DATA_W (B),
        .COEF_W (CW),
        .COEF0  (K0),
        .COEF1  (K1),
        .COEF2  (K2),
        .COEF3  (K3)
    ) u_da_fir4_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .in_ready   (in_ready),
        .out_result (out_result),
        .out_done   (out_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_next(input int s);
        hist[3] = hist[2];
        hist[2] = hist[1];
        hist[1] = hist[0];
        hist[0] = s;
        return K0 * hist[0] + K1 * hist[1] + K2 * hist[2] + K3 * hist[3];
    endfunction

    // noise: keep in_valid high with a junk sample while busy (R5)
    task automatic send(input int s, input bit noise, input string req);
        int exp;
        int got;
        while (!in_ready) @(negedge clk);
        in_valid  = 1'b1;
        in_sample = s[B-1:0];
        @(posedge clk);
        exp = model_next(s);
        @(negedge clk);
        if (noise) begin
            in_valid  = 1'b1;
            in_sample = ~s[B-1:0] ^ 8'h5A;
        end else begin
            in_valid = 1'b0;
        end
        for (int i = 0; i < B; i++) begin
            check(in_ready == 1'b0, "R4 ready low while busy", int'(in_ready), 0);
            check(out_done == 1'b0, "R3 no early done", int'(out_done), 0);
            if (i == B - 1) in_valid = 1'b0;
            @(negedge clk);
        end
        got = int'($signed(out_result));
        check(out_done == 1'b1, "R3 done after B edges", int'(out_done), 1);
        check(in_ready == 1'b1, "R4 ready back in done cycle", int'(in_ready), 1);
        check(got == exp, req, got, exp);
        last_exp = exp;
    endtask

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(out_done == 1'b0, "R3 done single cycle", int'(out_done), 0);
            check(int'($signed(out_result)) == last_exp, "R7 result holds",
                  int'($signed(out_result)), last_exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R3 watchdog actual=running expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #(CLK_PERIOD * 2 + 1);
        check(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
        check(out_done == 1'b0, "R1 done low in reset", int'(out_done), 0);
        check(out_result == '0, "R1 result zero in reset", int'(out_result), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        check(out_result == '0, "R1 result after reset", int'(out_result), 0);

        // R8: impulse response walks the table address bits
        send(1, 1'b0, "R8 impulse tap0");
        send(0, 1'b0, "R8 impulse tap1");
        send(0, 1'b0, "R8 impulse tap2");
        send(0, 1'b0, "R8 impulse tap3");
        send(0, 1'b0, "R6 history flushed");

        // R9: extremes of the signed range
        for (int i = 0; i < 4; i++) send(-(1 << (B - 1)), 1'b0, "R9 most negative");
        for (int i = 0; i < 4; i++) send((1 << (B - 1)) - 1, 1'b0, "R9 most positive");
        for (int i = 0; i < 4; i++) send((i % 2 == 0) ? -(1 << (B - 1)) : (1 << (B - 1)) - 1,
                                         1'b0, "R9 alternating extremes");

        // R2 sweep of every sample value, with R5 noise and R6 idle gaps
        for (int v = -(1 << (B - 1)); v < (1 << (B - 1)); v++) begin
            send(v, (v % 5) == 0, ((v % 5) == 0) ? "R5 busy input ignored" : "R2 sweep");
            if ((v % 7) == 0) idle_gap(3);
        end

        // R6: long idle gap, then a sequence that depends on the history
        idle_gap(10);
        send(3, 1'b0, "R6 after long gap");
        send(-7, 1'b1, "R5 noise during pass");
        idle_gap(2);
        send(100, 1'b0, "R2 final");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule